// File: doc/BRIEF.md
# Capture/Compare Interval Timer

This block is a single timer channel built around an up-counter. One control bit picks between two ways of working. In the first, the counter runs free and wraps. A rising edge on an external input copies the current count into a capture/compare register and raises an interrupt. In the second, the counter restarts from zero each time it equals that register. Each such match raises the interrupt and toggles a timer output, which gives a square wave whose half-period is the register value plus one.

Software drives the block through a small register port that takes one word per cycle. A control word carries a run bit, a write-only clear strobe, the mode bit and a lock bit. While the lock bit is set the mode cannot be changed. Starting takes effect on the next clock. Stopping is delayed by a fixed number of clocks, during which the counter keeps advancing.

There is no streaming data path, so the block uses no valid/ready handshake. The write strobe and the read select are plain control pins. A write is always accepted in the cycle it is presented, so back-pressure never occurs.

Top module: `capcmp_timer`

## Requirements
- R1: After reset the counter, the capture/compare register and every control bit read as 0, and `tout` and `irq` are low.
- R2: A control write (address 0) with the run bit (bit 0) set makes the channel active from the next clock edge. The count first reads 1 one clock after the write edge, when it started from 0.
- R3: A control write with the run bit clear, made while running, lets the count advance on exactly STOP_LAT (default 4) further clock edges. After that the count holds its value. `tout` is low whenever the channel is inactive.
- R4: In free-run mode (mode bit 2 = 0) an active counter steps from 0xFFFF to 0x0000.
- R5: In free-run mode, a rising edge on `cap_in` is detected after a two-flip-flop synchronizer. The clock edge after detection stores the count into the capture/compare register and raises `irq`. Capture takes precedence over a same-cycle write to address 1.
- R6: In match-and-clear mode (mode bit 2 = 1), an active counter equal to the capture/compare register clears to 0 on the next edge. On that same edge `irq` is raised and `tout` toggles.
- R7: A control write with the clear bit (bit 1) set forces the count to 0 and `tout` low, and suppresses a match in that cycle. A capture in the same cycle stores the pre-clear count. The clear bit always reads back 0.
- R8: While the lock bit (bit 3) reads 1, control writes leave the mode bit unchanged. A write that sets the lock and the mode together from the unlocked state is accepted.
- R9: `irq` is high for one cycle per event and is low in any cycle following a cycle without an event.
- R10: Read address 0 returns {lock bit 3, mode bit 2, 0 at bit 1, run bit 0}, address 1 the capture/compare register, address 2 the count, and address 3 zero. Writes to addresses 2 and 3 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe, one word per cycle |
| reg_waddr | input | 2 | Write address (0 control, 1 capture/compare) |
| reg_wdata | input | CNT_W | Write data |
| reg_raddr | input | 2 | Read address |
| reg_rdata | output | CNT_W | Combinational read data |
| cap_in | input | 1 | Asynchronous capture edge input |
| tout | output | 1 | Timer output, toggles on compare match |
| irq | output | 1 | Single-cycle interrupt pulse |

## Verification
Some properties are checked by assertions on every cycle. Among them are the mode lock, the start and the hold of the stop window, the counter holding while inactive, the wrap, the clear on a match, the effect of a software clear, and the capture of the pre-edge count together with the interrupt. Other behaviours can only be shown by the bench's scenarios. These are the exact four-edge stop delay seen as count values, the two-stage latency of the synchronizer, a capture that coincides with a clear, the square-wave period in match mode, the read-back layout and the writes to addresses that are ignored. The bench covers these with directed cases and with a long seeded random run compared against a reference model.

// File: rtl/capcmp_pkg.sv
package capcmp_pkg;
  localparam int CTRL_EN   = 0;
  localparam int CTRL_CLR  = 1;
  localparam int CTRL_MODE = 2;
  localparam int CTRL_PWR  = 3;
  localparam int CTRL_W    = 4;

  typedef enum logic [1:0] {
    ADDR_CTRL = 2'd0,
    ADDR_CCR  = 2'd1,
    ADDR_CNT  = 2'd2,
    ADDR_NONE = 2'd3
  } reg_addr_e;

  typedef enum logic {
    MODE_FREE_CAPTURE = 1'b0,
    MODE_MATCH_CLEAR  = 1'b1
  } tmr_mode_e;
endpackage

// File: rtl/capcmp_ctrl.sv
module capcmp_ctrl
  import capcmp_pkg::*;
#(
  parameter int STOP_LAT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctrl,
  input  logic [CTRL_W-1:0] ctrl_d,
  output logic              en_o,
  output tmr_mode_e         mode_o,
  output logic              pwr_o,
  output logic              act_o,
  output logic              clr_o
);
  localparam int SC_W = $clog2(STOP_LAT + 1);
  localparam logic [SC_W-1:0] SC_LAST = SC_W'(STOP_LAT - 1);

  logic            en_q;
  logic            pwr_q;
  logic            act_q;
  tmr_mode_e       mode_q;
  logic [SC_W-1:0] sc_q;

  assign clr_o  = wr_ctrl & ctrl_d[CTRL_CLR];
  assign en_o   = en_q;
  assign pwr_o  = pwr_q;
  assign act_o  = act_q;
  assign mode_o = mode_q;

  // Lock, mode and run bits.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      pwr_q  <= 1'b0;
      mode_q <= MODE_FREE_CAPTURE;
    end else if (wr_ctrl) begin
      en_q  <= ctrl_d[CTRL_EN];
      pwr_q <= ctrl_d[CTRL_PWR];
      if (!pwr_q) mode_q <= tmr_mode_e'(ctrl_d[CTRL_MODE]);
    end
  end

  // Activity: start on the next edge, stop after a fixed window.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      sc_q  <= '0;
    end else if (wr_ctrl && ctrl_d[CTRL_EN]) begin
      act_q <= 1'b1;
      sc_q  <= '0;
    end else if (wr_ctrl && en_q) begin
      sc_q <= '0;
    end else if (!en_q && act_q) begin
      if (sc_q == SC_LAST) act_q <= 1'b0;
      else                 sc_q  <= sc_q + SC_W'(1);
    end
  end

  AST_PWR_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && pwr_q) |=> $stable(mode_q)); // R8
  AST_PWR_JOINT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && !pwr_q) |=> (mode_q == tmr_mode_e'($past(ctrl_d[CTRL_MODE])))); // R8
  AST_START_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && ctrl_d[CTRL_EN]) |=> act_q); // R2
  AST_STOP_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && act_q && sc_q != SC_LAST && !wr_ctrl) |=> act_q); // R3
endmodule

// File: rtl/capcmp_edge.sv
module capcmp_edge #(
  parameter int SYNC_N = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise_o
);
  logic [SYNC_N:0] chain;
  logic            last_q;

  assign chain[0] = din;

  for (genvar s = 0; s < SYNC_N; s++) begin : g_sync
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[s+1] <= 1'b0;
      else        chain[s+1] <= chain[s];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= chain[SYNC_N];
  end

  assign rise_o = chain[SYNC_N] & ~last_q;

  AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o); // R5
endmodule

// File: rtl/capcmp_core.sv
module capcmp_core
  import capcmp_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             act_i,
  input  tmr_mode_e        mode_i,
  input  logic             clr_i,
  input  logic             rise_i,
  input  logic             ccr_wr_i,
  input  logic [CNT_W-1:0] ccr_d_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] ccr_o,
  output logic             tout_o,
  output logic             irq_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] ccr_q;
  logic             tout_q;
  logic             irq_q;
  logic             cap_ev;
  logic             match_ev;

  assign cap_ev   = (mode_i == MODE_FREE_CAPTURE) && rise_i;
  assign match_ev = (mode_i == MODE_MATCH_CLEAR) && act_i && (cnt_q == ccr_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      ccr_q  <= '0;
      tout_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (clr_i || match_ev) cnt_q <= '0;
      else if (act_i)        cnt_q <= cnt_q + CNT_W'(1);

      if (cap_ev)        ccr_q <= cnt_q;
      else if (ccr_wr_i) ccr_q <= ccr_d_i;

      irq_q <= cap_ev | (match_ev & ~clr_i);

      if (clr_i || !act_i) tout_q <= 1'b0;
      else if (match_ev)   tout_q <= ~tout_q;
    end
  end

  assign cnt_o  = cnt_q;
  assign ccr_o  = ccr_q;
  assign irq_o  = irq_q;
  assign tout_o = tout_q & act_i;

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!act_i && !clr_i) |=> (cnt_q == $past(cnt_q))); // R3
  AST_FREE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (act_i && mode_i == MODE_FREE_CAPTURE && !clr_i && cnt_q == '1) |=> (cnt_q == '0)); // R4
  AST_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == MODE_FREE_CAPTURE && rise_i) |=> (ccr_q == $past(cnt_q) && irq_o)); // R5
  AST_MATCH_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == MODE_MATCH_CLEAR && act_i && cnt_q == ccr_q && !clr_i) |=> (cnt_q == '0 && irq_o)); // R6
  AST_SOFT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cnt_q == '0 && !tout_q)); // R7
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!rise_i && !(mode_i == MODE_MATCH_CLEAR && act_i)) |=> !irq_o); // R9
endmodule

// File: rtl/capcmp_timer.sv
module capcmp_timer
  import capcmp_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int STOP_LAT = 4,
  parameter int SYNC_N   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [1:0]       reg_waddr,
  input  logic [CNT_W-1:0] reg_wdata,
  input  logic [1:0]       reg_raddr,
  output logic [CNT_W-1:0] reg_rdata,
  input  logic             cap_in,
  output logic             tout,
  output logic             irq
);
  logic             wr_ctrl;
  logic             wr_ccr;
  logic             en;
  logic             pwr;
  logic             act;
  logic             clr;
  logic             rise;
  tmr_mode_e        mode;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] ccr;
  logic [CNT_W-1:0] ctrl_rd;

  assign wr_ctrl = reg_wr && (reg_addr_e'(reg_waddr) == ADDR_CTRL);
  assign wr_ccr  = reg_wr && (reg_addr_e'(reg_waddr) == ADDR_CCR);

  capcmp_ctrl #(.STOP_LAT(STOP_LAT)) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_ctrl(wr_ctrl),
    .ctrl_d (reg_wdata[CTRL_W-1:0]),
    .en_o   (en),
    .mode_o (mode),
    .pwr_o  (pwr),
    .act_o  (act),
    .clr_o  (clr)
  );

  capcmp_edge #(.SYNC_N(SYNC_N)) u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (cap_in),
    .rise_o(rise)
  );

  capcmp_core #(.CNT_W(CNT_W)) u_core (
    .clk     (clk),
    .rst_n   (rst_n),
    .act_i   (act),
    .mode_i  (mode),
    .clr_i   (clr),
    .rise_i  (rise),
    .ccr_wr_i(wr_ccr),
    .ccr_d_i (reg_wdata),
    .cnt_o   (cnt),
    .ccr_o   (ccr),
    .tout_o  (tout),
    .irq_o   (irq)
  );

  always_comb begin
    ctrl_rd            = '0;
    ctrl_rd[CTRL_EN]   = en;
    ctrl_rd[CTRL_MODE] = mode;
    ctrl_rd[CTRL_PWR]  = pwr;
  end

  always_comb begin
    case (reg_addr_e'(reg_raddr))
      ADDR_CTRL: reg_rdata = ctrl_rd;
      ADDR_CCR:  reg_rdata = ccr;
      ADDR_CNT:  reg_rdata = cnt;
      default:   reg_rdata = '0;
    endcase
  end
endmodule

// File: tb/sim_capcmp_timer.sv
module sim_capcmp_timer;
  localparam int CLK_NS = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_waddr = 2'd0;
  logic [15:0] reg_wdata = 16'd0;
  logic [1:0]  reg_raddr = 2'd2;
  logic [15:0] reg_rdata;
  logic        cap_in = 1'b0;
  logic        tout;
  logic        irq;

  int    total = 0;
  int    bad = 0;
  bit    chk_on = 1'b0;
  bit    done = 1'b0;
  string cur_tag = "R1";

  always #(CLK_NS/2) clk = ~clk;

  capcmp_timer u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_waddr(reg_waddr),
    .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
    .cap_in(cap_in), .tout(tout), .irq(irq)
  );

  // Reference model state
  logic [15:0] m_cnt, m_ccr;
  logic        m_mode, m_pwr, m_en, m_act, m_tout, m_irq;
  logic [2:0]  m_sc;
  logic        m_s1, m_s2, m_last;

  function automatic logic [15:0] m_read(input logic [1:0] a);
    case (a)
      2'd0: m_read = {12'd0, m_pwr, m_mode, 1'b0, m_en};
      2'd1: m_read = m_ccr;
      2'd2: m_read = m_cnt;
      default: m_read = 16'd0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_ccr = 0; m_mode = 0; m_pwr = 0; m_en = 0; m_act = 0;
      m_tout = 0; m_irq = 0; m_sc = 0; m_s1 = 0; m_s2 = 0; m_last = 0;
    end else begin
      logic wc, wq, clr, cap, mt, rise;
      logic [15:0] n_cnt, n_ccr;
      logic n_tout, n_act;
      logic [2:0] n_sc;
      rise = m_s2 & ~m_last;
      wc   = reg_wr && reg_waddr == 2'd0;
      wq   = reg_wr && reg_waddr == 2'd1;
      clr  = wc && reg_wdata[1];
      cap  = !m_mode && rise;
      mt   = m_mode && m_act && (m_cnt == m_ccr);
      n_cnt = (clr || mt) ? 16'd0 : (m_act ? m_cnt + 16'd1 : m_cnt);
      n_ccr = cap ? m_cnt : (wq ? reg_wdata : m_ccr);
      n_tout = (clr || !m_act) ? 1'b0 : (mt ? ~m_tout : m_tout);
      n_act = m_act; n_sc = m_sc;
      if (wc && reg_wdata[0]) begin n_act = 1; n_sc = 0; end
      else if (wc && m_en) n_sc = 0;
      else if (!m_en && m_act) begin
        if (m_sc == 3'd3) n_act = 0; else n_sc = m_sc + 3'd1;
      end
      m_irq = cap | (mt & ~clr);
      if (wc) begin
        if (!m_pwr) m_mode = reg_wdata[2];
        m_pwr = reg_wdata[3];
        m_en  = reg_wdata[0];
      end
      m_cnt = n_cnt; m_ccr = n_ccr; m_tout = n_tout; m_act = n_act; m_sc = n_sc;
      m_last = m_s2; m_s2 = m_s1; m_s1 = cap_in;
    end
  end

  // Every-cycle comparison against the model
  always @(negedge clk) begin
    if (chk_on && !done) begin
      total += 3;
      if (reg_rdata !== m_read(reg_raddr)) begin
        bad++; $display("FAIL %s: rdata[%0d] got=%h exp=%h", cur_tag, reg_raddr, reg_rdata, m_read(reg_raddr));
      end
      if (irq !== m_irq) begin
        bad++; $display("FAIL %s R9: irq got=%b exp=%b", cur_tag, irq, m_irq);
      end
      if (tout !== (m_tout & m_act)) begin
        bad++; $display("FAIL %s R3: tout got=%b exp=%b", cur_tag, tout, m_tout & m_act);
      end
    end
  end

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    total++;
    if (got !== exp) begin
      bad++; $display("FAIL %s: got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    reg_wr = 1'b1; reg_waddr = a; reg_wdata = d;
    step();
    reg_wr = 1'b0;
  endtask

  task automatic at_neg();
    @(negedge clk);
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] v);
    #1 reg_raddr = a;
    #1 v = reg_rdata;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_NS * 190000);
    bad++; total++;
    $display("FAIL watchdog: got=running exp=finished");
    finish_run();
  end

  initial begin
    logic [15:0] v, w;
    void'($urandom(32'd20240611));
    repeat (3) step();
    rst_n = 1'b1;
    step();
    chk_on = 1'b1;

    // R1 reset state
    at_neg(); rd(2'd0, v); chk("R1 ctrl", v, 16'd0);
    rd(2'd1, v); chk("R1 ccr", v, 16'd0);
    rd(2'd2, v); chk("R1 cnt", v, 16'd0);
    chk("R1 tout", {15'd0, tout}, 16'd0);
    chk("R1 irq", {15'd0, irq}, 16'd0);

    // R2 start latency
    cur_tag = "R2";
    wr(2'd0, 16'h0001);
    at_neg(); rd(2'd2, v); chk("R2 cnt at write edge", v, 16'd0);
    step(); at_neg(); rd(2'd2, v); chk("R2 cnt one edge later", v, 16'd1);
    repeat (5) step();

    // R3 stop latency
    cur_tag = "R3";
    wr(2'd0, 16'h0000);
    at_neg(); rd(2'd2, v);
    repeat (4) step();
    at_neg(); rd(2'd2, w); chk("R3 four more steps", w, v + 16'd4);
    repeat (6) step();
    at_neg(); rd(2'd2, w); chk("R3 held", w, v + 16'd4);
    chk("R3 tout low", {15'd0, tout}, 16'd0);

    // R10 map and ignored writes
    cur_tag = "R10";
    wr(2'd2, 16'h1234); wr(2'd3, 16'hBEEF);
    at_neg(); rd(2'd2, w); chk("R10 count write ignored", w, v + 16'd4);
    rd(2'd3, w); chk("R10 addr3 reads 0", w, 16'd0);

    // R8 lock
    cur_tag = "R8";
    wr(2'd0, 16'h000C); at_neg(); rd(2'd0, w); chk("R8 joint write", w, 16'h000C);
    wr(2'd0, 16'h0008); at_neg(); rd(2'd0, w); chk("R8 mode locked", w, 16'h000C);
    wr(2'd0, 16'h0000); at_neg(); rd(2'd0, w); chk("R8 unlock keeps mode", w, 16'h0004);
    wr(2'd0, 16'h0000); at_neg(); rd(2'd0, w); chk("R8 mode writable", w, 16'h0000);

    // R6 match and clear, ccr = 5
    cur_tag = "R6";
    wr(2'd1, 16'd5);
    wr(2'd0, 16'h0007);
    repeat (5) step();
    at_neg(); rd(2'd2, w); chk("R6 cnt reaches ccr", w, 16'd5);
    chk("R6 irq before match", {15'd0, irq}, 16'd0);
    step(); at_neg(); rd(2'd2, w); chk("R6 cnt cleared", w, 16'd0);
    chk("R6 irq on match", {15'd0, irq}, 16'd1);
    chk("R6 tout toggled", {15'd0, tout}, 16'd1);
    step(); at_neg(); chk("R9 irq single cycle", {15'd0, irq}, 16'd0);
    repeat (30) step();

    // R5 capture after synchronizer
    cur_tag = "R5";
    cap_in = 1'b1;
    wr(2'd0, 16'h0003);
    step(); step();
    at_neg(); rd(2'd1, w); chk("R5 captured count", w, 16'd1);
    chk("R5 irq", {15'd0, irq}, 16'd1);

    // R7 clear coinciding with capture
    cur_tag = "R7";
    cap_in = 1'b0;
    repeat (4) step();
    cap_in = 1'b1;
    step(); step();
    at_neg(); rd(2'd2, v);
    wr(2'd0, 16'h0003);
    at_neg(); rd(2'd1, w); chk("R7 pre-clear capture", w, v);
    rd(2'd2, w); chk("R7 count cleared", w, 16'd0);
    rd(2'd0, w); chk("R7 clear reads 0", w, 16'h0001);
    chk("R7 irq", {15'd0, irq}, 16'd1);
    cap_in = 1'b0;

    // R4 wrap in free-run
    cur_tag = "R4";
    wr(2'd0, 16'h0003);
    repeat (65535) step();
    at_neg(); rd(2'd2, w); chk("R4 top value", w, 16'hFFFF);
    step(); at_neg(); rd(2'd2, w); chk("R4 wrap to zero", w, 16'h0000);

    // Random phase checked by the model (R5 R6 R8 R9)
    cur_tag = "R9";
    for (int i = 0; i < 20000; i++) begin
      logic [15:0] d;
      reg_raddr = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 9) == 0) cap_in = ~cap_in;
      case ($urandom_range(0, 19))
        0: begin
          d = 16'd0;
          d[0] = ($urandom_range(0, 9) < 7);
          d[1] = ($urandom_range(0, 4) == 0);
          d[2] = 1'($urandom_range(0, 1));
          d[3] = ($urandom_range(0, 9) < 3);
          reg_wr = 1'b1; reg_waddr = 2'd0; reg_wdata = d;
        end
        1: begin
          reg_wr = 1'b1; reg_waddr = 2'd1; reg_wdata = 16'($urandom_range(0, 47));
        end
        default: reg_wr = 1'b0;
      endcase
      step();
    end
    reg_wr = 1'b0;
    step(); step();
    finish_run();
  end
endmodule